// File: doc/BRIEF.md
# Row-Hit-First Request Scheduler

This block chooses which queued DRAM burst request goes next. The queue lives outside the block. Its contents come in every cycle as flat vectors, and each entry carries a valid bit, a bank number, a row number and an age tag. The block keeps its own table, one row per bank, of whether a row is open, which row it is, and how many accesses that row has had since it was activated. From this table it picks one queue slot. It also reports what the command sequencer must do for that slot: a column access only, an activate of an idle bank, or a precharge followed by an activate.

The selection policy can be changed at run time. In oldest-first mode, the oldest valid entry always wins. In row-hit-first mode, an entry that hits the open row of its bank wins over entries that miss, and age decides among the hits. An open row serves at most a fixed number of accesses (16 by default). After that, hits to it are no longer preferred, and the next access to that bank reopens the row.

A second run-time input selects the page handling. In open-page mode the row stays open after an access. In close-page mode every issued access leaves its bank precharged. The table changes only when the consumer asserts `issue_i`, which accepts the current pick.

Top module: `row_hit_sched`

## Requirements
- R1: `pick_valid_o` is high exactly when at least one `q_valid_i` bit is set, and `pick_idx_o` then names a valid slot (defaults: 32 slots, 8 banks).
- R2: With `policy_i`=0 the pick is the oldest valid entry. Entry a is older than b when (age_a − age_b) mod 2^AGE_W has its top bit set. On equal ages the lower index wins.
- R3: With `policy_i`=1 the pick is the oldest eligible row hit. If there is no eligible row hit, the pick is the oldest valid entry.
- R4: An entry is an eligible row hit when its bank is open, the open row equals the entry's row, and that bank's access count is below ROW_CAP.
- R5: `pick_cmd_o` is 0 (column only) for an eligible hit, 1 (activate) when the bank is idle, and 2 (precharge then activate) when the bank holds another row or is capped. The value 3 never appears.
- R6: On an accepted pick in open-page mode, a column access adds one to that bank's count. An activate or a precharge-then-activate opens the new row and sets the count to 1.
- R7: On an accepted pick with `page_close_i`=1, the bank becomes idle. The next access to that bank is never a column access.
- R8: After reset every bank is idle.
- R9: No activation of a row serves more than ROW_CAP (16) accesses, even while further hits to that row are queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 1 | 0 oldest-first, 1 row-hit-first |
| page_close_i | input | 1 | 0 keep row open, 1 precharge after each access |
| q_valid_i | input | QUEUE_DEPTH | Slot valid bits |
| q_bank_i | input | QUEUE_DEPTH*BANK_W | Bank of each slot, slot 0 in the low bits |
| q_row_i | input | QUEUE_DEPTH*ROW_W | Row of each slot |
| q_age_i | input | QUEUE_DEPTH*AGE_W | Sequence tag of each slot |
| issue_i | input | 1 | Current pick accepted this cycle |
| pick_valid_o | output | 1 | A pick is presented |
| pick_idx_o | output | IDX_W | Chosen slot |
| pick_cmd_o | output | 2 | Needed command: 0 column, 1 activate, 2 precharge+activate |

## Verification
The hardest state to reach from the ports is a bank whose row has used up its access allowance while hits to that row are still queued. A random queue almost never issues sixteen hits in a row to one bank. A directed run therefore fills every slot with the same bank and row and accepts twenty picks. The expected sequence is one activate, fifteen column accesses, then a precharge-then-activate. Age wraparound is forced with tags on both sides of the modulus. Random sweeps over a reduced configuration (8 slots, 4 banks, 4 rows) then cover all four combinations of policy and page handling against an arithmetic model of the bank table.

// File: rtl/row_sched_pkg.sv
package row_sched_pkg;
  typedef enum logic [1:0] {
    CMD_COL     = 2'd0,
    CMD_ACT     = 2'd1,
    CMD_PRE_ACT = 2'd2
  } sched_cmd_e;
endpackage

// File: rtl/rs_bank_state.sv
module rs_bank_state
  import row_sched_pkg::*;
#(
  parameter int ROW_W   = 14,
  parameter int ROW_CAP = 16,
  localparam int CNT_W  = $clog2(ROW_CAP + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  sched_cmd_e       upd_cmd_i,
  input  logic [ROW_W-1:0] upd_row_i,
  input  logic             close_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             capped_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_o <= 1'b0;
      row_o  <= '0;
      cnt_q  <= '0;
    end else if (upd_i) begin
      if (close_i) begin
        open_o <= 1'b0;
        cnt_q  <= '0;
      end else if (upd_cmd_i == CMD_COL) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        open_o <= 1'b1;
        row_o  <= upd_row_i;
        cnt_q  <= CNT_W'(1);
      end
    end
  end

  assign capped_o = (cnt_q >= CNT_W'(ROW_CAP));
endmodule

// File: rtl/rs_entry_class.sv
module rs_entry_class
  import row_sched_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                            valid_i,
  input  logic [BANK_W-1:0]               bank_i,
  input  logic [ROW_W-1:0]                row_i,
  input  logic [NUM_BANKS-1:0]            bank_open_i,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row_i,
  input  logic [NUM_BANKS-1:0]            bank_capped_i,
  output logic                            hit_o,
  output sched_cmd_e                      cmd_o
);
  logic open_w, same_row_w, capped_w, hit_raw_w;

  assign open_w     = bank_open_i[bank_i];
  assign same_row_w = (bank_row_i[bank_i] == row_i);
  assign capped_w   = bank_capped_i[bank_i];
  assign hit_raw_w  = open_w && same_row_w && !capped_w;
  assign hit_o      = valid_i && hit_raw_w;

  always_comb begin
    if (!open_w)        cmd_o = CMD_ACT;
    else if (hit_raw_w) cmd_o = CMD_COL;
    else                cmd_o = CMD_PRE_ACT;
  end
endmodule

// File: rtl/rs_age_arb.sv
module rs_age_arb #(
  parameter int QUEUE_DEPTH = 32,
  parameter int AGE_W       = 6,
  localparam int IDX_W      = $clog2(QUEUE_DEPTH)
) (
  input  logic [QUEUE_DEPTH-1:0]       req_i,
  input  logic [QUEUE_DEPTH*AGE_W-1:0] age_i,
  output logic                         any_o,
  output logic [IDX_W-1:0]             idx_o
);
  // modular compare: a precedes b when a-b is negative in AGE_W bits
  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  logic [AGE_W-1:0] best_age;

  always_comb begin
    any_o    = 1'b0;
    idx_o    = '0;
    best_age = '0;
    for (int i = 0; i < QUEUE_DEPTH; i++) begin
      if (req_i[i] && (!any_o || older(age_i[i*AGE_W +: AGE_W], best_age))) begin
        any_o    = 1'b1;
        idx_o    = IDX_W'(i);
        best_age = age_i[i*AGE_W +: AGE_W];
      end
    end
  end
endmodule

// File: rtl/row_hit_sched.sv
module row_hit_sched
  import row_sched_pkg::*;
#(
  parameter int QUEUE_DEPTH = 32,
  parameter int NUM_BANKS   = 8,
  parameter int ROW_W       = 14,
  parameter int AGE_W       = 6,
  parameter int ROW_CAP     = 16,
  localparam int IDX_W      = $clog2(QUEUE_DEPTH),
  localparam int BANK_W     = $clog2(NUM_BANKS)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            policy_i,
  input  logic                            page_close_i,
  input  logic [QUEUE_DEPTH-1:0]          q_valid_i,
  input  logic [QUEUE_DEPTH*BANK_W-1:0]   q_bank_i,
  input  logic [QUEUE_DEPTH*ROW_W-1:0]    q_row_i,
  input  logic [QUEUE_DEPTH*AGE_W-1:0]    q_age_i,
  input  logic                            issue_i,
  output logic                            pick_valid_o,
  output logic [IDX_W-1:0]                pick_idx_o,
  output logic [1:0]                      pick_cmd_o
);
  logic [NUM_BANKS-1:0]            bank_open_w;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_row_w;
  logic [NUM_BANKS-1:0]            bank_capped_w;

  logic [BANK_W-1:0] e_bank [QUEUE_DEPTH];
  logic [ROW_W-1:0]  e_row  [QUEUE_DEPTH];
  sched_cmd_e        e_cmd  [QUEUE_DEPTH];
  logic [QUEUE_DEPTH-1:0] e_hit_w;
  logic [QUEUE_DEPTH-1:0] hit_req_w;

  logic             hit_any_w, all_any_w;
  logic [IDX_W-1:0] hit_idx_w, all_idx_w;
  sched_cmd_e       pick_cmd_w;
  logic [BANK_W-1:0] pick_bank_w;
  logic [ROW_W-1:0]  pick_row_w;
  logic              accept_w;

  for (genvar q = 0; q < QUEUE_DEPTH; q++) begin : g_entry
    assign e_bank[q] = q_bank_i[q*BANK_W +: BANK_W];
    assign e_row[q]  = q_row_i[q*ROW_W +: ROW_W];
    rs_entry_class #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_class (
      .valid_i       (q_valid_i[q]),
      .bank_i        (e_bank[q]),
      .row_i         (e_row[q]),
      .bank_open_i   (bank_open_w),
      .bank_row_i    (bank_row_w),
      .bank_capped_i (bank_capped_w),
      .hit_o         (e_hit_w[q]),
      .cmd_o         (e_cmd[q])
    );
  end

  assign hit_req_w = e_hit_w & {QUEUE_DEPTH{policy_i}};

  rs_age_arb #(.QUEUE_DEPTH(QUEUE_DEPTH), .AGE_W(AGE_W)) u_hit_arb (
    .req_i (hit_req_w),
    .age_i (q_age_i),
    .any_o (hit_any_w),
    .idx_o (hit_idx_w)
  );

  rs_age_arb #(.QUEUE_DEPTH(QUEUE_DEPTH), .AGE_W(AGE_W)) u_all_arb (
    .req_i (q_valid_i),
    .age_i (q_age_i),
    .any_o (all_any_w),
    .idx_o (all_idx_w)
  );

  assign pick_valid_o = all_any_w;
  assign pick_idx_o   = hit_any_w ? hit_idx_w : all_idx_w;
  assign pick_cmd_w   = e_cmd[pick_idx_o];
  assign pick_cmd_o   = pick_cmd_w;
  assign pick_bank_w  = e_bank[pick_idx_o];
  assign pick_row_w   = e_row[pick_idx_o];
  assign accept_w     = issue_i && all_any_w;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rs_bank_state #(.ROW_W(ROW_W), .ROW_CAP(ROW_CAP)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .upd_i     (accept_w && (pick_bank_w == BANK_W'(b))),
      .upd_cmd_i (pick_cmd_w),
      .upd_row_i (pick_row_w),
      .close_i   (page_close_i),
      .open_o    (bank_open_w[b]),
      .row_o     (bank_row_w[b]),
      .capped_o  (bank_capped_w[b])
    );
  end
endmodule

// File: rtl/row_hit_sched_chk.sv
module row_hit_sched_chk #(
  parameter int QUEUE_DEPTH = 32,
  parameter int NUM_BANKS   = 8,
  parameter int ROW_CAP     = 16,
  localparam int IDX_W      = $clog2(QUEUE_DEPTH),
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int RUN_W      = $clog2(ROW_CAP + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   policy_i,
  input logic                   page_close_i,
  input logic [QUEUE_DEPTH-1:0] q_valid_i,
  input logic                   issue_i,
  input logic                   pick_valid_i,
  input logic [IDX_W-1:0]       pick_idx_i,
  input logic [1:0]             pick_cmd_i,
  input logic [BANK_W-1:0]      pick_bank_i,
  input logic [QUEUE_DEPTH-1:0] hit_req_i
);
  logic [RUN_W-1:0] run_q [NUM_BANKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) run_q[b] <= '0;
    end else if (issue_i && pick_valid_i) begin
      if (pick_cmd_i == 2'd0) run_q[pick_bank_i] <= run_q[pick_bank_i] + 1'b1;
      else                    run_q[pick_bank_i] <= RUN_W'(1);
    end
  end

  // R1
  pick_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_i == (|q_valid_i));
  // R1
  pick_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_i |-> q_valid_i[pick_idx_i]);
  // R5
  cmd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pick_valid_i |-> (pick_cmd_i != 2'd3));
  // R3
  hit_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i && pick_valid_i && pick_cmd_i != 2'd0) |-> (hit_req_i == '0));
  // R9
  row_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && pick_valid_i && pick_cmd_i == 2'd0) |-> (run_q[pick_bank_i] < RUN_W'(ROW_CAP)));
  // R7
  close_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && pick_valid_i && page_close_i) |=>
      !(pick_valid_i && pick_bank_i == $past(pick_bank_i) && pick_cmd_i == 2'd0));
endmodule

bind row_hit_sched row_hit_sched_chk #(
  .QUEUE_DEPTH (QUEUE_DEPTH),
  .NUM_BANKS   (NUM_BANKS),
  .ROW_CAP     (ROW_CAP)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .policy_i     (policy_i),
  .page_close_i (page_close_i),
  .q_valid_i    (q_valid_i),
  .issue_i      (issue_i),
  .pick_valid_i (pick_valid_o),
  .pick_idx_i   (pick_idx_o),
  .pick_cmd_i   (pick_cmd_o),
  .pick_bank_i  (pick_bank_w),
  .hit_req_i    (hit_req_w)
);

// File: tb/row_hit_sched_tb_top.sv
module row_hit_sched_tb_top;
  localparam int Q    = 8;
  localparam int NB   = 4;
  localparam int RW   = 2;
  localparam int AW   = 5;
  localparam int CAP  = 16;
  localparam int IW   = $clog2(Q);
  localparam int BW   = $clog2(NB);
  localparam int AMOD = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy = 1'b0, page_close = 1'b0, issue = 1'b0;
  logic [Q-1:0] q_valid = '0;
  logic [Q*BW-1:0] q_bank = '0;
  logic [Q*RW-1:0] q_row = '0;
  logic [Q*AW-1:0] q_age = '0;
  logic pick_valid;
  logic [IW-1:0] pick_idx;
  logic [1:0] pick_cmd;

  always #5 clk = ~clk;

  row_hit_sched #(.QUEUE_DEPTH(Q), .NUM_BANKS(NB), .ROW_W(RW), .AGE_W(AW), .ROW_CAP(CAP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .page_close_i(page_close),
    .q_valid_i(q_valid), .q_bank_i(q_bank), .q_row_i(q_row), .q_age_i(q_age),
    .issue_i(issue), .pick_valid_o(pick_valid), .pick_idx_o(pick_idx), .pick_cmd_o(pick_cmd)
  );

  int n_chk = 0, n_bad = 0;
  int v[Q], bk[Q], rw[Q], ag[Q];
  int m_open[NB], m_row[NB], m_cnt[NB];
  int e_v, e_i, e_c;

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit older(int a, int b);
    return (((a - b) % AMOD + AMOD) % AMOD) >= (AMOD / 2);
  endfunction

  function automatic int ent_cmd(int k);
    if (!m_open[bk[k]]) return 1;
    if (m_row[bk[k]] == rw[k] && m_cnt[bk[k]] < CAP) return 0;
    return 2;
  endfunction

  task automatic compute_exp();
    int hi = -1, ai = -1;
    for (int k = 0; k < Q; k++) begin
      if (!v[k]) continue;
      if (ai < 0 || older(ag[k], ag[ai])) ai = k;
      if (policy && ent_cmd(k) == 0 && (hi < 0 || older(ag[k], ag[hi]))) hi = k;
    end
    e_v = (ai >= 0);
    e_i = (hi >= 0) ? hi : ((ai >= 0) ? ai : 0);
    e_c = e_v ? ent_cmd(e_i) : 0;
  endtask

  task automatic drive();
    for (int k = 0; k < Q; k++) begin
      q_valid[k] = v[k][0];
      q_bank[k*BW +: BW] = BW'(bk[k]);
      q_row[k*RW +: RW] = RW'(rw[k]);
      q_age[k*AW +: AW] = AW'(ag[k]);
    end
  endtask

  // one cycle: drive, compare, optionally accept and update model (R6, R7)
  task automatic step(bit iss, string rsel);
    @(negedge clk);
    drive();
    issue = iss;
    #1;
    compute_exp();
    check("R1", pick_valid, e_v);
    if (e_v) begin
      check(rsel, pick_idx, e_i);
      check(page_close ? "R7" : "R5", pick_cmd, e_c);
    end
    @(posedge clk);
    if (iss && e_v) begin
      if (page_close) begin m_open[bk[e_i]] = 0; m_cnt[bk[e_i]] = 0; end
      else if (e_c == 0) m_cnt[bk[e_i]]++;
      else begin m_open[bk[e_i]] = 1; m_row[bk[e_i]] = rw[e_i]; m_cnt[bk[e_i]] = 1; end
    end
  endtask

  task automatic clear_q();
    for (int k = 0; k < Q; k++) begin v[k] = 0; bk[k] = 0; rw[k] = 0; ag[k] = k; end
  endtask

  bit done = 0;

  initial begin
    for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_row[b] = 0; m_cnt[b] = 0; end
    clear_q();
    drive();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R8: idle banks after reset
    v[3] = 1; bk[3] = 2; rw[3] = 1;
    @(negedge clk); drive(); #1;
    check("R8", pick_cmd, 1);
    check("R8", pick_idx, 3);

    // R1: empty queue
    clear_q();
    @(negedge clk); drive(); #1;
    check("R1", pick_valid, 0);

    // R2: age wraparound both ways
    clear_q();
    v[0] = 1; v[1] = 1; bk[1] = 1; ag[0] = 30; ag[1] = 2;
    @(negedge clk); drive(); #1;
    check("R2", pick_idx, 0);
    ag[0] = 2; ag[1] = 30;
    @(negedge clk); drive(); #1;
    check("R2", pick_idx, 1);

    // R9, R6: all slots hit one row; 20 accepted picks
    policy = 1; page_close = 0;
    for (int k = 0; k < Q; k++) begin v[k] = 1; bk[k] = 1; rw[k] = 3; ag[k] = (7 * k) % AMOD; end
    for (int n = 0; n < 20; n++) begin
      int exp_c;
      exp_c = (n == 0) ? 1 : (n == CAP) ? 2 : 0;
      @(negedge clk); drive(); issue = 1; #1;
      check(n == CAP ? "R9" : "R6", pick_cmd, exp_c);
      compute_exp();
      @(posedge clk);
      if (e_c == 0) m_cnt[1]++;
      else begin m_open[1] = 1; m_row[1] = 3; m_cnt[1] = 1; end
    end
    issue = 0;

    // R4: younger hit beats older miss in the same bank
    clear_q();
    v[0] = 1; bk[0] = 1; rw[0] = 2; ag[0] = 0;
    v[5] = 1; bk[5] = 1; rw[5] = 3; ag[5] = 4;
    @(negedge clk); drive(); #1;
    check("R4", pick_idx, 5);
    check("R4", pick_cmd, 0);
    policy = 0;
    @(negedge clk); #1;
    check("R2", pick_idx, 0);
    check("R5", pick_cmd, 2);

    // sweeps over all policy / page combinations
    for (int mode = 0; mode < 4; mode++) begin
      policy = mode[0];
      page_close = mode[1];
      for (int s = 0; s < 600; s++) begin
        int base, rot;
        base = $urandom % AMOD;
        rot = $urandom % Q;
        for (int k = 0; k < Q; k++) begin
          v[k] = (($urandom % 4) != 0);
          bk[k] = $urandom % NB;
          rw[k] = $urandom % (1 << RW);
          ag[k] = (base + ((k * 3 + rot) % Q)) % AMOD;
        end
        step(($urandom % 4) != 0, policy ? "R3" : "R2");
      end
    end
    issue = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule